// File: doc/BRIEF.md
# EEPROM Block-Read Sequencer

This block reads a run of bytes from a serial EEPROM on its own. It does this by operating the byte-level register interface of a two-wire bus master that reports its progress as status codes. The caller supplies a device address, a memory offset of one or two bytes and a byte count, then pulses `start`. The sequencer resets and configures the bus master. It addresses the device for writing and sends the offset. It then turns the bus round with a repeated start and addresses the device again for reading. It fetches the data and closes the bus with a stop.

Every command the sequencer issues is followed by a polling loop. The loop reads the master's status register once every `POLL_GAP` cycles, at most `POLL_LIMIT` times, and looks for the single code that the step should produce. If that code does not appear within the limit, the transfer is abandoned and an error is held. Bytes leave the block on a valid/ready stream in the order the bus delivered them. The sequencer waits while the consumer stalls.

Top module: `eeprom_rd_seq`

## Requirements
- R1: After an accepted start, the first four register writes are, in order: 0 to the soft-reset register (offset 0x1C), 0 to the own-address register (0x00), 0 to the extended own-address register (0x10), and 0x24 to the clock-divider register (0x0C). No control write comes before them.
- R2: The first control-register (0x08) write is 0x40 (enable only) and must be answered by status 0xF8. The next is 0x60 (start plus enable) and must be answered by 0x08.
- R3: The device address with bit 0 cleared is written to the data register (0x04), followed by control 0x40. The expected status is 0x18.
- R4: With a two-byte offset, the high offset byte is sent before the low byte. With a one-byte offset, only the low byte is sent. Each byte is a data write followed by control 0x40, and each expects status 0x28.
- R5: Control 0x60 is then written and must be answered by 0x10. Next come a data write of the device address with bit 0 set and control 0x40, which expect 0x40.
- R6: For each byte except the last, control is 0x44 and the expected status is 0x50. For the last byte, control is 0x40 and the expected status is 0x58. Once the status matches, the byte is fetched with one read of the data register.
- R7: The transfer ends with control 0x50, which expects 0xF8. `done` then pulses for one cycle with `busy` low, `err` low and `xfer_len` equal to the requested count.
- R8: The status register is read once every `POLL_GAP` cycles while waiting. If `POLL_LIMIT` reads all miss, `done` pulses, `err` is set, `last_status` holds the last value read, and no further register access follows.
- R9: `err`, `last_status` and `xfer_len` keep their values while idle until the next start request.
- R10: A start request with a count of zero produces `done` and `err` in the next cycle, with `last_status` = 0xFF and no register access.
- R11: Output bytes appear in bus order. `out_data` is held while `out_valid` is high and `out_ready` is low. No register access takes place while a byte is waiting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request a transfer (sampled while idle) |
| dev_addr | input | 8 | Device address byte; bit 0 is replaced per phase |
| mem_off | input | 16 | Memory offset inside the device |
| off_wide | input | 1 | 1: two-byte offset, 0: one-byte offset |
| rd_len | input | CNT_W | Number of bytes to read |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |
| err | output | 1 | Last transfer failed or was rejected |
| last_status | output | 8 | Last status code observed |
| xfer_len | output | CNT_W | Bytes delivered by the last transfer |
| out_valid | output | 1 | Output byte available |
| out_data | output | 8 | Output byte |
| out_ready | input | 1 | Consumer accepts the byte |
| ctl_wr | output | 1 | Register write strobe to the bus master |
| ctl_rd | output | 1 | Register read strobe to the bus master |
| ctl_addr | output | 5 | Register byte offset |
| ctl_wdata | output | 8 | Register write data |
| ctl_rdata | input | 8 | Register read data, valid in the strobe cycle |

## Verification
The hardest case to reach is a status mismatch at one particular step deep in the sequence, such as the second offset byte or a middle data byte. The aim is to watch the sequencer stop cleanly there, with exactly the bytes already accepted counted. The bench stub answers the k-th control write with a wrong code (0x38) instead of the expected one. The fault is swept across every step of a two-byte-offset, three-byte read. Each run is checked for the truncated register log, the partial byte count and the held status. Stall patterns on `out_ready` separately probe the hold behaviour of the stream.

// File: rtl/eeprom_seq_pkg.sv
package eeprom_seq_pkg;

    // register byte offsets of the bus master
    localparam logic [4:0] RG_OWNADR = 5'h00;
    localparam logic [4:0] RG_DATA   = 5'h04;
    localparam logic [4:0] RG_CTRL   = 5'h08;
    localparam logic [4:0] RG_STAT   = 5'h0C;  // read: status, write: divider
    localparam logic [4:0] RG_XADR   = 5'h10;
    localparam logic [4:0] RG_SRST   = 5'h1C;

    // control bits
    localparam logic [7:0] CB_ACK   = 8'h04;
    localparam logic [7:0] CB_STOP  = 8'h10;
    localparam logic [7:0] CB_START = 8'h20;
    localparam logic [7:0] CB_EN    = 8'h40;

    localparam logic [7:0] DIVIDER_CFG = 8'h24;

    // status codes
    localparam logic [7:0] SC_IDLE     = 8'hF8;
    localparam logic [7:0] SC_STARTED  = 8'h08;
    localparam logic [7:0] SC_RESTART  = 8'h10;
    localparam logic [7:0] SC_WADR_ACK = 8'h18;
    localparam logic [7:0] SC_WDAT_ACK = 8'h28;
    localparam logic [7:0] SC_RADR_ACK = 8'h40;
    localparam logic [7:0] SC_RDAT_ACK = 8'h50;
    localparam logic [7:0] SC_RDAT_NAK = 8'h58;
    localparam logic [7:0] SC_REJECT   = 8'hFF;

    typedef enum logic [3:0] {
        PH_EN, PH_START, PH_WADR, PH_OFFHI, PH_OFFLO,
        PH_RESTART, PH_RADR, PH_RDATA, PH_RLAST, PH_STOP
    } phase_e;

    typedef enum logic [2:0] {
        S_IDLE, S_INIT, S_DATA, S_CTRL, S_POLL, S_FETCH, S_PUSH
    } seq_e;

endpackage

// File: rtl/eeprom_step_dec.sv
module eeprom_step_dec
    import eeprom_seq_pkg::*;
(
    input  phase_e      phase,
    input  logic [7:0]  dev,
    input  logic [15:0] off,
    output logic        has_data,
    output logic [7:0]  data_val,
    output logic [7:0]  ctrl_val,
    output logic [7:0]  expect_code
);
    always_comb begin
        has_data    = 1'b0;
        data_val    = 8'h00;
        ctrl_val    = CB_EN;
        expect_code = SC_IDLE;
        case (phase)
            PH_EN: begin
                expect_code = SC_IDLE;
            end
            PH_START: begin
                ctrl_val    = CB_EN | CB_START;
                expect_code = SC_STARTED;
            end
            PH_WADR: begin
                has_data    = 1'b1;
                data_val    = {dev[7:1], 1'b0};
                expect_code = SC_WADR_ACK;
            end
            PH_OFFHI: begin
                has_data    = 1'b1;
                data_val    = off[15:8];
                expect_code = SC_WDAT_ACK;
            end
            PH_OFFLO: begin
                has_data    = 1'b1;
                data_val    = off[7:0];
                expect_code = SC_WDAT_ACK;
            end
            PH_RESTART: begin
                ctrl_val    = CB_EN | CB_START;
                expect_code = SC_RESTART;
            end
            PH_RADR: begin
                has_data    = 1'b1;
                data_val    = {dev[7:1], 1'b1};
                expect_code = SC_RADR_ACK;
            end
            PH_RDATA: begin
                ctrl_val    = CB_EN | CB_ACK;
                expect_code = SC_RDAT_ACK;
            end
            PH_RLAST: begin
                expect_code = SC_RDAT_NAK;
            end
            PH_STOP: begin
                ctrl_val    = CB_EN | CB_STOP;
                expect_code = SC_IDLE;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/eeprom_poll_timer.sv
module eeprom_poll_timer #(
    parameter int POLL_GAP   = 1000,
    parameter int POLL_LIMIT = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick,
    output logic last_try
);
    localparam int GAP_W = $clog2(POLL_GAP + 1);
    localparam int TRY_W = $clog2(POLL_LIMIT + 1);

    typedef struct packed {
        logic [GAP_W-1:0] gap;
        logic [TRY_W-1:0] tries;
    } tmr_t;

    tmr_t q, d;

    assign tick     = run && (q.gap == GAP_W'(POLL_GAP - 1));
    assign last_try = (q.tries == TRY_W'(POLL_LIMIT - 1));

    always_comb begin
        d = q;
        if (!run) begin
            d.gap   = '0;
            d.tries = '0;
        end else if (tick) begin
            d.gap   = '0;
            d.tries = q.tries + 1'b1;
        end else begin
            d.gap = q.gap + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/eeprom_rd_seq.sv
module eeprom_rd_seq
    import eeprom_seq_pkg::*;
#(
    parameter int CNT_W      = 8,
    parameter int POLL_GAP   = 1000,
    parameter int POLL_LIMIT = 1000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [7:0]       dev_addr,
    input  logic [15:0]      mem_off,
    input  logic             off_wide,
    input  logic [CNT_W-1:0] rd_len,
    output logic             busy,
    output logic             done,
    output logic             err,
    output logic [7:0]       last_status,
    output logic [CNT_W-1:0] xfer_len,
    output logic             out_valid,
    output logic [7:0]       out_data,
    input  logic             out_ready,
    output logic             ctl_wr,
    output logic             ctl_rd,
    output logic [4:0]       ctl_addr,
    output logic [7:0]       ctl_wdata,
    input  logic [7:0]       ctl_rdata
);
    typedef struct packed {
        seq_e             st;
        phase_e           ph;
        logic [1:0]       idx;
        logic [7:0]       dev;
        logic [15:0]      off;
        logic             wide;
        logic [CNT_W-1:0] rem;
        logic [CNT_W-1:0] cnt;
        logic [7:0]       byte_v;
        logic             err;
        logic [7:0]       stat;
        logic             done;
    } seq_t;

    seq_t q, d;

    logic       dec_has_data;
    logic [7:0] dec_data, dec_ctrl, dec_expect;
    logic       poll_run, poll_tick, poll_last;

    eeprom_step_dec u_dec (
        .phase       (q.ph),
        .dev         (q.dev),
        .off         (q.off),
        .has_data    (dec_has_data),
        .data_val    (dec_data),
        .ctrl_val    (dec_ctrl),
        .expect_code (dec_expect)
    );

    assign poll_run = (q.st == S_POLL);

    eeprom_poll_timer #(.POLL_GAP(POLL_GAP), .POLL_LIMIT(POLL_LIMIT)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (poll_run),
        .tick     (poll_tick),
        .last_try (poll_last)
    );

    function automatic phase_e after_phase(phase_e p, logic wide, logic [CNT_W-1:0] rem);
        case (p)
            PH_EN:      return PH_START;
            PH_START:   return PH_WADR;
            PH_WADR:    return wide ? PH_OFFHI : PH_OFFLO;
            PH_OFFHI:   return PH_OFFLO;
            PH_OFFLO:   return PH_RESTART;
            PH_RESTART: return PH_RADR;
            PH_RADR:    return (rem == CNT_W'(1)) ? PH_RLAST : PH_RDATA;
            default:    return PH_STOP;
        endcase
    endfunction

    always_comb begin
        d         = q;
        d.done    = 1'b0;
        ctl_wr    = 1'b0;
        ctl_rd    = 1'b0;
        ctl_addr  = RG_CTRL;
        ctl_wdata = 8'h00;
        case (q.st)
            S_IDLE: begin
                if (start) begin
                    d.cnt = '0;
                    if (rd_len == '0) begin
                        d.done = 1'b1;
                        d.err  = 1'b1;
                        d.stat = SC_REJECT;
                    end else begin
                        d.err  = 1'b0;
                        d.st   = S_INIT;
                        d.idx  = 2'd0;
                        d.dev  = dev_addr;
                        d.off  = off_wide ? mem_off : {8'h00, mem_off[7:0]};
                        d.wide = off_wide;
                        d.rem  = rd_len;
                        d.ph   = PH_EN;
                    end
                end
            end
            S_INIT: begin
                ctl_wr = 1'b1;
                case (q.idx)
                    2'd0:    ctl_addr = RG_SRST;
                    2'd1:    ctl_addr = RG_OWNADR;
                    2'd2:    ctl_addr = RG_XADR;
                    default: begin
                        ctl_addr  = RG_STAT;
                        ctl_wdata = DIVIDER_CFG;
                    end
                endcase
                d.idx = q.idx + 2'd1;
                if (q.idx == 2'd3) d.st = S_DATA;
            end
            S_DATA: begin
                ctl_wr = 1'b1;
                if (dec_has_data) begin
                    ctl_addr  = RG_DATA;
                    ctl_wdata = dec_data;
                    d.st      = S_CTRL;
                end else begin
                    ctl_wdata = dec_ctrl;
                    d.st      = S_POLL;
                end
            end
            S_CTRL: begin
                ctl_wr    = 1'b1;
                ctl_wdata = dec_ctrl;
                d.st      = S_POLL;
            end
            S_POLL: begin
                if (poll_tick) begin
                    ctl_rd   = 1'b1;
                    ctl_addr = RG_STAT;
                    d.stat   = ctl_rdata;
                    if (ctl_rdata == dec_expect) begin
                        if (q.ph == PH_RDATA || q.ph == PH_RLAST) begin
                            d.st = S_FETCH;
                        end else if (q.ph == PH_STOP) begin
                            d.st   = S_IDLE;
                            d.done = 1'b1;
                        end else begin
                            d.ph = after_phase(q.ph, q.wide, q.rem);
                            d.st = S_DATA;
                        end
                    end else if (poll_last) begin
                        d.st   = S_IDLE;
                        d.err  = 1'b1;
                        d.done = 1'b1;
                    end
                end
            end
            S_FETCH: begin
                ctl_rd   = 1'b1;
                ctl_addr = RG_DATA;
                d.byte_v = ctl_rdata;
                d.st     = S_PUSH;
            end
            S_PUSH: begin
                if (out_ready) begin
                    d.cnt = q.cnt + 1'b1;
                    d.rem = q.rem - 1'b1;
                    d.st  = S_DATA;
                    if (q.ph == PH_RLAST)            d.ph = PH_STOP;
                    else if (q.rem == CNT_W'(2))     d.ph = PH_RLAST;
                    else                             d.ph = PH_RDATA;
                end
            end
            default: d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.st   <= S_IDLE;
            q.ph   <= PH_EN;
            q.stat <= SC_IDLE;
        end else begin
            q <= d;
        end
    end

    assign busy        = (q.st != S_IDLE);
    assign done        = q.done;
    assign err         = q.err;
    assign last_status = q.stat;
    assign xfer_len    = q.cnt;
    assign out_valid   = (q.st == S_PUSH);
    assign out_data    = q.byte_v;

endmodule

// File: rtl/eeprom_seq_chk.sv
module eeprom_seq_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic [CNT_W-1:0] rd_len,
    input logic             busy,
    input logic             done,
    input logic             err,
    input logic [7:0]       last_status,
    input logic [CNT_W-1:0] xfer_len,
    input logic             out_valid,
    input logic [7:0]       out_data,
    input logic             out_ready,
    input logic             ctl_wr,
    input logic             ctl_rd
);
    // R11
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data));

    // R11
    no_access_while_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !ctl_wr && !ctl_rd);

    // R7
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R9
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && !start |=> $stable(err) && $stable(last_status) && $stable(xfer_len));

    // R10
    zero_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && start && rd_len == '0 |=> done && err && !busy && !ctl_wr && !ctl_rd);

    // R8
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !ctl_wr && !ctl_rd);

endmodule

bind eeprom_rd_seq eeprom_seq_chk #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .rd_len      (rd_len),
    .busy        (busy),
    .done        (done),
    .err         (err),
    .last_status (last_status),
    .xfer_len    (xfer_len),
    .out_valid   (out_valid),
    .out_data    (out_data),
    .out_ready   (out_ready),
    .ctl_wr      (ctl_wr),
    .ctl_rd      (ctl_rd)
);

// File: tb/sim_eeprom_rd_seq.sv
`timescale 1ns/1ps
module sim_eeprom_rd_seq;
    localparam int CW   = 8;
    localparam int GAP  = 4;
    localparam int LIM  = 8;
    localparam int RESP = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [7:0]    dev_addr = 8'h00;
    logic [15:0]   mem_off = 16'h0;
    logic          off_wide = 1'b0;
    logic [CW-1:0] rd_len = '0;
    logic          busy, done, err, out_valid, out_ready;
    logic [7:0]    last_status, out_data, ctl_wdata, ctl_rdata;
    logic [CW-1:0] xfer_len;
    logic          ctl_wr, ctl_rd;
    logic [4:0]    ctl_addr;

    always #5 clk = ~clk;

    eeprom_rd_seq #(.CNT_W(CW), .POLL_GAP(GAP), .POLL_LIMIT(LIM)) u0 (.*);

    int checks = 0;
    int fails  = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // ---------------- register stub ----------------
    int   log_a[$];
    int   log_d[$];
    int   codes[$];
    int   fault_at = -1;
    int   nctl = 0;
    int   rdidx = 0;
    int   dly = 0;
    int   base_adr = 0;
    logic [7:0] stat_reg = 8'hF8;
    logic [7:0] pend = 8'h00;
    int   got[$];
    int   ctl_in_push = 0;

    function automatic int eep(int a);
        return (a * 37 + 11) & 8'hFF;
    endfunction

    assign ctl_rdata = (ctl_addr == 5'h0C) ? stat_reg :
                       (ctl_addr == 5'h04) ? 8'(eep(base_adr + rdidx)) : 8'h00;

    always @(posedge clk) begin
        if (ctl_wr) begin
            log_a.push_back(int'(ctl_addr));
            log_d.push_back(int'(ctl_wdata));
            if (ctl_addr == 5'h08) begin
                stat_reg <= 8'hE0;
                dly      <= RESP;
                pend     <= (nctl == fault_at || nctl >= codes.size()) ? 8'h38 : 8'(codes[nctl]);
                nctl     <= nctl + 1;
            end
        end else if (dly > 0) begin
            dly <= dly - 1;
            if (dly == 1) stat_reg <= pend;
        end
        if (ctl_rd && ctl_addr == 5'h04) rdidx <= rdidx + 1;
        if (out_valid && out_ready) got.push_back(int'(out_data));
    end

    // ---------------- per-clock stream monitor ----------------
    logic       pv_valid = 1'b0, pv_ready = 1'b0;
    logic [7:0] pv_data = 8'h00;
    always @(negedge clk) begin
        if (rst_n) begin
            if (pv_valid && !pv_ready)
                check(out_valid && out_data == pv_data, "R11", "held byte", int'(out_data), int'(pv_data));
            if (out_valid && (ctl_wr || ctl_rd)) ctl_in_push++;
        end
        pv_valid = out_valid;
        pv_ready = out_ready;
        pv_data  = out_data;
    end

    // ---------------- expected model ----------------
    int exp_a[$];
    int exp_d[$];
    int ctl_pos[$];
    int is_rd[$];

    task automatic add_step(input bit has_d, input int dv, input int cv, input int code, input bit rd);
        if (has_d) begin exp_a.push_back(4); exp_d.push_back(dv); end
        exp_a.push_back(8); exp_d.push_back(cv);
        ctl_pos.push_back(exp_a.size() - 1);
        codes.push_back(code);
        is_rd.push_back(rd);
    endtask

    task automatic build(input int dev, input int off, input bit wide, input int n);
        exp_a = {}; exp_d = {}; ctl_pos = {}; codes = {}; is_rd = {};
        exp_a.push_back(28); exp_d.push_back(0);
        exp_a.push_back(0);  exp_d.push_back(0);
        exp_a.push_back(16); exp_d.push_back(0);
        exp_a.push_back(12); exp_d.push_back(36);
        add_step(0, 0, 8'h40, 8'hF8, 0);
        add_step(0, 0, 8'h60, 8'h08, 0);
        add_step(1, dev & 8'hFE, 8'h40, 8'h18, 0);
        if (wide) add_step(1, (off >> 8) & 8'hFF, 8'h40, 8'h28, 0);
        add_step(1, off & 8'hFF, 8'h40, 8'h28, 0);
        add_step(0, 0, 8'h60, 8'h10, 0);
        add_step(1, dev | 1, 8'h40, 8'h40, 0);
        for (int i = 1; i < n; i++) add_step(0, 0, 8'h44, 8'h50, 1);
        add_step(0, 0, 8'h40, 8'h58, 1);
        add_step(0, 0, 8'h50, 8'hF8, 0);
    endtask

    int ready_mode = 0;
    int cyc = 0;
    always @(posedge clk) begin
        cyc <= cyc + 1;
        #1;
        out_ready = (ready_mode == 0) ? 1'b1 : ((cyc % 3) == 0);
    end

    task automatic run_case(input string tag, input int dev, input int off, input bit wide,
                            input int n, input int fault, input int rmode);
        int lim;
        int nlog;
        int nbytes;
        int base;
        build(dev, off, wide, n);
        @(posedge clk); #2;
        log_a = {}; log_d = {}; got = {};
        fault_at = fault; ready_mode = rmode; ctl_in_push = 0;
        base = wide ? off : (off & 8'hFF);
        base_adr = base;
        dev_addr = 8'(dev); mem_off = 16'(off); off_wide = wide; rd_len = CW'(n);
        start = 1'b1;
        @(posedge clk); #2;
        start = 1'b0;
        nctl = 0; rdidx = 0;
        lim = 0;
        while (!done && lim < 20000) begin @(negedge clk); lim++; end
        check(lim < 20000, tag, "completion", lim, 0);
        @(negedge clk);
        if (fault < 0) begin
            nlog = exp_a.size();
            nbytes = n;
        end else begin
            nlog = ctl_pos[fault] + 1;
            nbytes = 0;
            for (int s = 0; s < fault; s++) nbytes += is_rd[s];
        end
        check(log_a.size() == nlog, tag, "register write count", log_a.size(), nlog);
        for (int i = 0; i < nlog && i < log_a.size(); i++) begin
            check(log_a[i] == exp_a[i] && log_d[i] == exp_d[i], (i < 4) ? "R1" : tag,
                  $sformatf("write %0d addr/data", i), (log_a[i] << 8) | log_d[i], (exp_a[i] << 8) | exp_d[i]);
        end
        check(got.size() == nbytes, "R11", "byte count", got.size(), nbytes);
        for (int i = 0; i < nbytes && i < got.size(); i++)
            check(got[i] == eep(base + i), "R6", $sformatf("byte %0d", i), got[i], eep(base + i));
        check(xfer_len == CW'(nbytes), "R7", "xfer_len", int'(xfer_len), nbytes);
        check(ctl_in_push == 0, "R11", "access while byte waiting", ctl_in_push, 0);
        if (fault < 0) begin
            check(!err && last_status == 8'hF8, "R7", "success flags", {err, last_status}, 8'hF8);
        end else begin
            check(err && last_status == 8'h38, "R8", "timeout flags", {err, last_status}, 9'h138);
        end
        repeat (15) @(negedge clk);
        check(err == (fault >= 0) && xfer_len == CW'(nbytes) && !busy, "R9", "held result",
              {busy, err}, (fault >= 0) ? 1 : 0);
        check(log_a.size() == nlog, "R8", "no access after end", log_a.size(), nlog);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        check(1'b0, "WATCHDOG", "run time", 0, 1);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int l0;
        repeat (3) @(posedge clk);
        #2;
        check(!busy && !done && !err && !out_valid && !ctl_wr && !ctl_rd && xfer_len == 0,
              "R9", "reset state", {busy, done, err, out_valid}, 0);
        rst_n = 1'b1;
        repeat (2) @(posedge clk);

        run_case("R4", 8'hA0, 16'h0035, 1'b0, 1, -1, 0);       // one-byte offset, single byte
        run_case("R4", 8'hA1, 16'h1234, 1'b1, 4, -1, 0);       // two-byte offset, R3 bit0 cleared
        run_case("R5", 8'hAE, 16'h0102, 1'b1, 3, -1, 1);       // backpressure
        run_case("R6", 8'hA4, 16'h00F0, 1'b0, 5, -1, 1);

        // R10 zero count
        @(posedge clk); #2;
        l0 = log_a.size();
        rd_len = '0; start = 1'b1;
        @(posedge clk); #2;
        start = 1'b0;
        check(done && err && last_status == 8'hFF && !busy, "R10", "zero count reject",
              {done, err, last_status}, 10'h3FF);
        repeat (5) @(negedge clk);
        check(log_a.size() == l0, "R10", "no bus access", log_a.size(), l0);

        // R8 fault at every step of a two-byte offset, three-byte read (11 steps)
        for (int f = 0; f < 11; f++) begin
            run_case((f < 2) ? "R2" : "R8", 8'hA2, 16'h0300, 1'b1, 3, f, 0);
        end

        // recovery after error: R9 cleared by next start
        run_case("R7", 8'hA0, 16'h0010, 1'b0, 2, -1, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule